// File: doc/BRIEF.md
# Auxiliary-Winding Zero-Crossing and Mode Detector

This block watches a stream of digitised auxiliary-winding voltage samples in a primary-side flyback controller. Each switching cycle begins with a strobe at the instant the power switch turns off. From there the block counts valid samples. At a sample index equal to about 85% of the discharge time measured in the last completed cycle, it stores one sample as the held output-voltage estimate. After that capture, the first sample that falls more than a fixed offset below the held value marks the end of secondary diode conduction. The block emits a one-cycle zero-crossing pulse there and records the sample index as the new discharge time.

The held value drives three decisions. The first is a hysteretic choice between the normal current limit and the reduced power-limit current limit. The second is the switching-frequency word used during constant-current operation, which falls linearly as the held voltage drops and stops at a floor. The third is an output over-voltage request. If a cycle ends without a zero crossing, the next turn-off strobe raises a missing-crossing flag and the old discharge count is kept. All thresholds are parameters in ADC code units. With the default scaling, one code is 4 mV and one frequency unit is 0.25 kHz.

Top module: `zcd_mode_detect`

## Requirements
- R1: After reset the outputs are as follows: `zcd_pulse`=0, `zcd_miss`=0, `ovp_req`=0, `held_v`=0, `dis_time`=INIT_DIS (40), `lim_low`=1 (power limit), and `freq_word` equals the frequency mapping of a held value of 0.
- R2: Valid samples after a `gate_off` strobe are numbered from 1. Cycles with `smp_valid` low do not count. The sample whose index equals T = max(1, P - (P>>3) - (P>>5)) is captured into `held_v`, where P is `dis_time` at the strobe. `held_v` shows the new value one cycle after that sample.
- R3: After the capture, the first valid sample s with `held_v` - s > ZC_OFFSET (50) produces `zcd_pulse`=1 for exactly one cycle, and `dis_time` takes that sample's index. Both appear one cycle after the sample. A drop of exactly 50 does not count. Samples after a crossing are ignored until the next strobe.
- R4: On each `gate_off` strobe, `zcd_miss` becomes 1 if no crossing occurred since the previous strobe and 0 otherwise, one cycle later. The first strobe after reset gives 0. `dis_time` changes only together with `zcd_pulse`.
- R5: `lim_low` becomes 1 when `held_v` < LIM_ENTER (137), two cycles after the capturing sample.
- R6: `lim_low` returns to 0 only when `held_v` > LIM_EXIT (188). For 137 <= `held_v` <= 188 it keeps its last value.
- R7: Let d = `held_v` clamped to [CC_END=175, CC_KNEE=538] and r = ((CC_KNEE - d) * SLOPE_NUM) >> SLOPE_SH. Then `freq_word` = F_NOM - r (F_NOM=340), registered one cycle after `held_v`.
- R8: When r >= F_NOM - F_MIN, `freq_word` is held at F_MIN.
- R9: `ovp_req` is 1 exactly when `held_v` > OVP_LEVEL (700), registered one cycle after `held_v`.
- R10: Samples that arrive before the first strobe, or after a crossing, are ignored. A new strobe in mid-cycle restarts indexing and leaves `dis_time` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_off | input | 1 | One-cycle strobe at switch turn-off; starts a measurement cycle |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | W | Auxiliary-winding voltage sample, ADC codes |
| zcd_pulse | output | 1 | One-cycle zero-crossing marker |
| zcd_miss | output | 1 | Last completed cycle had no zero crossing |
| dis_time | output | CW | Discharge time in valid-sample counts |
| held_v | output | W | Held voltage sample |
| lim_low | output | 1 | 1 selects the power-limit current threshold |
| freq_word | output | FW | Target switching frequency, 0.25 kHz units |
| ovp_req | output | 1 | Output over-voltage request |

## Verification
The bench drives inputs just after a falling edge and reads outputs 5 ns after the following rising edge. Each result is compared in the cycle in which it is due. `held_v` is checked right after the edge that takes the capture sample. `zcd_pulse` and `dis_time` are checked right after the edge of the crossing sample. `zcd_miss` is checked right after the strobe edge. The limit select, frequency word and over-voltage request need one more register stage, so they are checked after an extra idle cycle. Before the capture index, sample values are offset by 20 codes, so only a capture at the exact index gives the expected held value.

// File: rtl/zcd_mode_pkg.sv
`timescale 1ns/1ps
package zcd_mode_pkg;

   typedef enum logic {
      LIM_NORMAL = 1'b0,
      LIM_POWER  = 1'b1
   } lim_sel_e;

   // 1 - 1/8 - 1/32 = 0.84375 of the previous discharge count, never below 1
   function automatic int unsigned tap85(input int unsigned prev);
      int unsigned t;
      t = prev - (prev >> 3) - (prev >> 5);
      return (t == 0) ? 1 : t;
   endfunction

endpackage

// File: rtl/zcd_disch_timer.sv
`timescale 1ns/1ps
module zcd_disch_timer #(
   parameter int W         = 10,
   parameter int CW        = 12,
   parameter int ZC_OFFSET = 50,
   parameter int INIT_DIS  = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_off,
   input  logic          smp_valid,
   input  logic [W-1:0]  smp_data,
   output logic          zcd_pulse,
   output logic          zcd_miss,
   output logic [CW-1:0] dis_time,
   output logic [W-1:0]  held_v
);
   import zcd_mode_pkg::*;

   localparam logic [CW-1:0] INIT_C   = CW'(INIT_DIS);
   localparam logic [CW-1:0] TAP0_C   = CW'(tap85(INIT_DIS));
   localparam logic [W:0]    OFS_C    = (W+1)'(ZC_OFFSET);
   localparam logic [CW-1:0] CNT_MAX  = '1;

   generate
      if (ZC_OFFSET <= 0 || ZC_OFFSET >= (1 << W)) begin : g_bad_ofs
         $error("ZC_OFFSET out of ADC range");
      end
      if (INIT_DIS < 1 || INIT_DIS >= (1 << CW)) begin : g_bad_init
         $error("INIT_DIS must fit the discharge counter");
      end
   endgenerate

   logic          active;
   logic          captured;
   logic          seen;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;
   logic [CW-1:0] tgt;
   logic          hit_tgt;
   logic          drop_det;

   assign cnt_nxt  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
   assign hit_tgt  = !captured && (cnt_nxt == tgt);
   assign drop_det = captured && (({1'b0, smp_data} + OFS_C) < {1'b0, held_v});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         captured  <= 1'b0;
         seen      <= 1'b1;
         cnt       <= '0;
         tgt       <= TAP0_C;
         held_v    <= '0;
         dis_time  <= INIT_C;
         zcd_pulse <= 1'b0;
         zcd_miss  <= 1'b0;
      end else begin
         zcd_pulse <= 1'b0;
         if (gate_off) begin
            active   <= 1'b1;
            captured <= 1'b0;
            cnt      <= '0;
            tgt      <= CW'(tap85(32'(dis_time)));
            zcd_miss <= !seen;
            seen     <= 1'b0;
         end else if (active && smp_valid) begin
            cnt <= cnt_nxt;
            if (hit_tgt) begin
               held_v   <= smp_data;
               captured <= 1'b1;
            end else if (drop_det) begin
               zcd_pulse <= 1'b1;
               dis_time  <= cnt_nxt;
               active    <= 1'b0;
               seen      <= 1'b1;
            end
         end
      end
   end

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_pulse |=> !zcd_pulse);
   a_r3_pulse_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_pulse |-> ($past(smp_valid) && !$past(gate_off)));
   a_r4_count_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dis_time) |-> zcd_pulse);
   a_r4_miss_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(zcd_miss) |-> $past(gate_off));

endmodule

// File: rtl/zcd_hold_modes.sv
`timescale 1ns/1ps
module zcd_hold_modes #(
   parameter int W         = 10,
   parameter int LIM_ENTER = 137,
   parameter int LIM_EXIT  = 188,
   parameter int OVP_LEVEL = 700
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] held_v,
   output logic         lim_low,
   output logic         ovp_req
);
   import zcd_mode_pkg::*;

   localparam logic [W-1:0] ENTER_C = W'(LIM_ENTER);
   localparam logic [W-1:0] EXIT_C  = W'(LIM_EXIT);
   localparam logic [W-1:0] OVP_C   = W'(OVP_LEVEL);

   generate
      if (LIM_ENTER >= LIM_EXIT) begin : g_bad_hyst
         $error("LIM_ENTER must lie below LIM_EXIT");
      end
      if (OVP_LEVEL >= (1 << W) || LIM_EXIT >= (1 << W)) begin : g_bad_range
         $error("mode thresholds exceed ADC range");
      end
   endgenerate

   lim_sel_e sel_q;
   lim_sel_e sel_d;

   always_comb begin
      sel_d = sel_q;
      if (held_v < ENTER_C)
         sel_d = LIM_POWER;
      else if (held_v > EXIT_C)
         sel_d = LIM_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= LIM_POWER;
         ovp_req <= 1'b0;
      end else begin
         sel_q   <= sel_d;
         ovp_req <= (held_v > OVP_C);
      end
   end

   assign lim_low = (sel_q == LIM_POWER);

   a_r5_enter_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lim_low) |-> ($past(held_v) < ENTER_C));
   a_r6_leave_power: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lim_low) |-> ($past(held_v) > EXIT_C));
   a_r9_ovp_level: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_req |-> ($past(held_v) > OVP_C));

endmodule

// File: rtl/zcd_freq_map.sv
`timescale 1ns/1ps
module zcd_freq_map #(
   parameter int W         = 10,
   parameter int FW        = 10,
   parameter int CC_KNEE   = 538,
   parameter int CC_END    = 175,
   parameter int F_NOM     = 340,
   parameter int F_MIN     = 104,
   parameter int SLOPE_NUM = 156,
   parameter int SLOPE_SH  = 8,
   parameter bit PIPE_FREQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  held_v,
   output logic [FW-1:0] freq_word
);
   localparam int PW = W + 16;
   localparam logic [W-1:0]  KNEE_C  = W'(CC_KNEE);
   localparam logic [W-1:0]  END_C   = W'(CC_END);
   localparam logic [15:0]   SLOPE_C = 16'(SLOPE_NUM);
   localparam logic [FW-1:0] FNOM_C  = FW'(F_NOM);
   localparam logic [FW-1:0] FMIN_C  = FW'(F_MIN);
   localparam logic [PW-1:0] SPAN_C  = PW'(F_NOM - F_MIN);

   generate
      if (CC_END >= CC_KNEE || CC_KNEE >= (1 << W)) begin : g_bad_knee
         $error("CC_END must lie below CC_KNEE within ADC range");
      end
      if (F_MIN > F_NOM || F_NOM >= (1 << FW)) begin : g_bad_freq
         $error("frequency limits inconsistent with FW");
      end
      if (SLOPE_NUM < 1 || SLOPE_NUM > 65535) begin : g_bad_slope
         $error("SLOPE_NUM must fit 16 bits");
      end
   endgenerate

   function automatic logic [FW-1:0] map_f(input logic [W-1:0] h);
      logic [W-1:0]  d;
      logic [PW-1:0] prod;
      logic [PW-1:0] red;
      d    = (h < END_C) ? END_C : ((h > KNEE_C) ? KNEE_C : h);
      prod = PW'(KNEE_C - d) * PW'(SLOPE_C);
      red  = prod >> SLOPE_SH;
      if (red >= SPAN_C)
         return FMIN_C;
      return FNOM_C - red[FW-1:0];
   endfunction

   generate
      if (PIPE_FREQ) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               freq_word <= map_f('0);
            else
               freq_word <= map_f(held_v);
         end
      end else begin : g_comb
         assign freq_word = map_f(held_v);
      end
   endgenerate

   a_r8_freq_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_word >= FMIN_C) && (freq_word <= FNOM_C));
   a_r7_flat_above_knee: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(held_v) >= KNEE_C) |-> (freq_word == FNOM_C || !PIPE_FREQ));

endmodule

// File: rtl/zcd_mode_detect.sv
`timescale 1ns/1ps
module zcd_mode_detect #(
   parameter int W         = 10,
   parameter int CW        = 12,
   parameter int FW        = 10,
   parameter int ZC_OFFSET = 50,
   parameter int INIT_DIS  = 40,
   parameter int LIM_ENTER = 137,
   parameter int LIM_EXIT  = 188,
   parameter int OVP_LEVEL = 700,
   parameter int CC_KNEE   = 538,
   parameter int CC_END    = 175,
   parameter int F_NOM     = 340,
   parameter int F_MIN     = 104,
   parameter int SLOPE_NUM = 156,
   parameter int SLOPE_SH  = 8,
   parameter bit PIPE_FREQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_off,
   input  logic          smp_valid,
   input  logic [W-1:0]  smp_data,
   output logic          zcd_pulse,
   output logic          zcd_miss,
   output logic [CW-1:0] dis_time,
   output logic [W-1:0]  held_v,
   output logic          lim_low,
   output logic [FW-1:0] freq_word,
   output logic          ovp_req
);
   generate
      if (W < 4 || CW < 4 || FW < 4) begin : g_bad_width
         $error("widths too small");
      end
   endgenerate

   zcd_disch_timer #(
      .W(W), .CW(CW), .ZC_OFFSET(ZC_OFFSET), .INIT_DIS(INIT_DIS)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .gate_off(gate_off),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .zcd_pulse(zcd_pulse), .zcd_miss(zcd_miss),
      .dis_time(dis_time), .held_v(held_v)
   );

   zcd_hold_modes #(
      .W(W), .LIM_ENTER(LIM_ENTER), .LIM_EXIT(LIM_EXIT), .OVP_LEVEL(OVP_LEVEL)
   ) i_modes (
      .clk(clk), .rst_n(rst_n), .held_v(held_v),
      .lim_low(lim_low), .ovp_req(ovp_req)
   );

   zcd_freq_map #(
      .W(W), .FW(FW), .CC_KNEE(CC_KNEE), .CC_END(CC_END),
      .F_NOM(F_NOM), .F_MIN(F_MIN), .SLOPE_NUM(SLOPE_NUM),
      .SLOPE_SH(SLOPE_SH), .PIPE_FREQ(PIPE_FREQ)
   ) i_freq (
      .clk(clk), .rst_n(rst_n), .held_v(held_v), .freq_word(freq_word)
   );

endmodule

// File: tb/test_zcd_mode_detect.sv
`timescale 1ns/1ps
module test_zcd_mode_detect;
   localparam int W  = 10;
   localparam int CW = 12;
   localparam int FW = 10;
   localparam int OFS = 50;
   localparam int FMIN_TB = 120;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gate_off = 1'b0;
   logic          smp_valid = 1'b0;
   logic [W-1:0]  smp_data = '0;
   logic          zcd_pulse;
   logic          zcd_miss;
   logic [CW-1:0] dis_time;
   logic [W-1:0]  held_v;
   logic          lim_low;
   logic [FW-1:0] freq_word;
   logic          ovp_req;

   int n_chk = 0;
   int n_fail = 0;
   int p_exp = 40;
   bit seen_exp = 1'b1;
   int held_exp = 0;
   bit lim_exp = 1'b1;

   always #10 clk = ~clk;

   zcd_mode_detect #(.F_MIN(FMIN_TB)) i_zcd_mode_detect (
      .clk(clk), .rst_n(rst_n), .gate_off(gate_off),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .zcd_pulse(zcd_pulse), .zcd_miss(zcd_miss), .dis_time(dis_time),
      .held_v(held_v), .lim_low(lim_low), .freq_word(freq_word),
      .ovp_req(ovp_req)
   );

   function automatic int tap(int p);
      int t;
      t = p - (p >> 3) - (p >> 5);
      return (t < 1) ? 1 : t;
   endfunction

   function automatic int fexp(int h);
      int d;
      int r;
      d = (h < 175) ? 175 : ((h > 538) ? 538 : h);
      r = ((538 - d) * 156) >> 8;
      return (r >= 340 - FMIN_TB) ? FMIN_TB : 340 - r;
   endfunction

   task automatic chk(string rq, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic put(bit go, bit v, int d);
      @(negedge clk);
      gate_off  = go;
      smp_valid = v;
      smp_data  = W'(d);
      @(posedge clk);
      #5;
      gate_off  = 1'b0;
      smp_valid = 1'b0;
   endtask

   task automatic check_modes();
      int f;
      chk("R4 discharge count kept", dis_time, p_exp);
      chk("R2 held value", held_v, held_exp);
      chk("R5 R6 limit select", lim_low, lim_exp);
      f = fexp(held_exp);
      if (f == FMIN_TB) chk("R8 frequency floor", freq_word, f);
      else chk("R7 frequency map", freq_word, f);
      chk("R9 over-voltage", ovp_req, (held_exp > 700) ? 1 : 0);
   endtask

   // One measurement cycle: strobe, then zidx valid samples
   task automatic run_cycle(int zidx, int hv, int drop, bit gaps);
      int t;
      int d;
      bit zc;
      t  = tap(p_exp);
      zc = 1'b0;
      put(1'b1, 1'b0, 0);
      chk("R4 missing-crossing flag", zcd_miss, seen_exp ? 0 : 1);
      seen_exp = 1'b0;
      for (int i = 1; i <= zidx; i++) begin
         if (i < t) d = hv + 20;
         else if (i == zidx) d = hv - drop;
         else d = hv;
         if (gaps && (i % 3 == 0)) begin
            put(1'b0, 1'b0, 0);
            chk("R2 invalid cycle not counted", zcd_pulse, 0);
         end
         put(1'b0, 1'b1, d);
         if (i == t && t < zidx) begin
            chk("R2 capture at tap index", held_v, hv);
            held_exp = hv;
            if (hv < 137) lim_exp = 1'b1;
            else if (hv > 188) lim_exp = 1'b0;
         end
         if (i == zidx && t < zidx && drop > OFS) begin
            chk("R3 crossing pulse", zcd_pulse, 1);
            chk("R3 discharge count", dis_time, zidx);
            p_exp = zidx;
            seen_exp = 1'b1;
            zc = 1'b1;
         end else begin
            chk("R3 no crossing", zcd_pulse, 0);
         end
      end
      if (zc) begin
         put(1'b0, 1'b1, 0);
         chk("R10 sample after crossing ignored", zcd_pulse, 0);
      end
      put(1'b0, 1'b0, 0);
      check_modes();
   endtask

   function automatic int pickz(int base);
      int t;
      t = tap(p_exp) + 1;
      return (base < t) ? t : base;
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int hv;
      int drop;
      int hl[18];
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pulse", zcd_pulse, 0);
      chk("R1 miss", zcd_miss, 0);
      chk("R1 ovp", ovp_req, 0);
      chk("R1 held", held_v, 0);
      chk("R1 count", dis_time, 40);
      chk("R1 limit", lim_low, 1);
      chk("R1 frequency", freq_word, fexp(0));

      // R10: samples before any strobe are ignored
      for (int i = 0; i < 5; i++) begin
         put(1'b0, 1'b1, (i == 0) ? 900 : 0);
         chk("R10 pre-strobe no pulse", zcd_pulse, 0);
         chk("R10 pre-strobe held", held_v, 0);
      end

      // Rising sweep
      for (int k = 0; k < 56; k++) begin
         hv   = 60 + k * 17;
         drop = 51 + (k % 5) * 30;
         if (drop > hv) drop = hv;
         run_cycle(pickz(5 + (k * 7) % 33), hv, drop, k[0]);
      end

      // Threshold boundaries in a falling then rising order
      hl = '{800, 701, 700, 539, 538, 400, 189, 188, 160, 137, 136, 150,
             188, 189, 175, 174, 100, 60};
      foreach (hl[j]) run_cycle(pickz(9 + j), hl[j], 55, j[0]);

      // R3 offset boundary: a drop of exactly 50 is no crossing
      run_cycle(pickz(12), 300, 50, 1'b0);
      chk("R3 drop of 50 keeps count", dis_time, p_exp);
      run_cycle(pickz(12), 300, 51, 1'b0);

      // R10 restart mid-cycle: short cycle with no capture, then full one
      run_cycle(1, 400, 0, 1'b0);
      chk("R10 restart keeps count", dis_time, p_exp);
      run_cycle(pickz(20), 420, 60, 1'b1);
      run_cycle(pickz(15), 250, 51, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule